// File: doc/BRIEF.md
# AXI4-Lite Broadcast Fanout with Per-Port Address Windows

This block joins one upstream AXI4-Lite manager to a fixed number of downstream AXI4-Lite subordinates. It has no address decoder. Every write and read request, with its address, protection, data and strobe, goes out on all downstream ports at once. The ready signals that come back are combined by OR before they go upstream. Responses are merged on the assumption that exactly one downstream subordinate answers each request.

A subordinate may raise its request readies before it sees a valid. On a plain broadcast, such a subordinate would acknowledge every access on the bus, including accesses meant for other ports. To prevent this, each port can be given an address window at elaboration. On a windowed port, the request valids sent to it and the request readies taken from it are forced low whenever the address lies outside the window. Writes are checked against the write address and reads against the read address, each with its own gate. The whole path is combinational and adds no latency.

Top module: `lbf_fanout`

## Requirements
- R1: The write address, write protection, write data, write strobe, read address and read protection reach every downstream port unchanged, whether or not the port has a window. On a port without a window, the write address, write data and read address valids are copies of the upstream valids.
- R2: Upstream write-address ready, write-data ready and read-address ready are each the OR, over all ports, of that port's gated ready. On a port without a window the gated ready is the raw ready.
- R3: On a windowed port the write gate is true only when the write address lies in [base, base+size). When the gate is false, that port's write-address valid and write-data valid are driven 0, and its write-address ready and write-data ready do not reach upstream.
- R4: On a windowed port the read gate compares the read address with the window, separately from the write gate. When the read gate is false, that port's read-address valid is driven 0 and its read-address ready does not reach upstream.
- R5: The window test uses only the low CMP_W address bits (28 by default). Address bits above them have no effect on either gate.
- R6: Upstream write-response valid is the OR of the downstream write-response valids. Upstream write-response code (2 bits) is taken from the port whose valid is high, and is 0 when no port is valid.
- R7: Upstream read-response valid is the OR of the downstream read-response valids. Upstream read data and read-response code are taken from the port whose valid is high, and are 0 when no port is valid.
- R8: Upstream write-response ready and read-response ready are sent unchanged to every downstream port.
- R9: Take a windowed port whose subordinate holds all request readies high while every other port holds them low. The upstream request readies are then high only for addresses inside that port's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| up_awaddr | input | ADDR_W | Upstream write address |
| up_awprot | input | 3 | Upstream write protection |
| up_awvalid | input | 1 | Upstream write address valid |
| up_awready | output | 1 | Upstream write address ready |
| up_wdata | input | DATA_W | Upstream write data |
| up_wstrb | input | DATA_W/8 | Upstream write strobe |
| up_wvalid | input | 1 | Upstream write data valid |
| up_wready | output | 1 | Upstream write data ready |
| up_bresp | output | 2 | Upstream write response code |
| up_bvalid | output | 1 | Upstream write response valid |
| up_bready | input | 1 | Upstream write response ready |
| up_araddr | input | ADDR_W | Upstream read address |
| up_arprot | input | 3 | Upstream read protection |
| up_arvalid | input | 1 | Upstream read address valid |
| up_arready | output | 1 | Upstream read address ready |
| up_rdata | output | DATA_W | Upstream read data |
| up_rresp | output | 2 | Upstream read response code |
| up_rvalid | output | 1 | Upstream read response valid |
| up_rready | input | 1 | Upstream read response ready |
| dn_awaddr | output | N_PORTS*ADDR_W | Write address per port, port k at slice k |
| dn_awprot | output | N_PORTS*3 | Write protection per port |
| dn_awvalid | output | N_PORTS | Gated write address valid per port |
| dn_awready | input | N_PORTS | Write address ready per port |
| dn_wdata | output | N_PORTS*DATA_W | Write data per port |
| dn_wstrb | output | N_PORTS*DATA_W/8 | Write strobe per port |
| dn_wvalid | output | N_PORTS | Gated write data valid per port |
| dn_wready | input | N_PORTS | Write data ready per port |
| dn_bresp | input | N_PORTS*2 | Write response code per port |
| dn_bvalid | input | N_PORTS | Write response valid per port |
| dn_bready | output | N_PORTS | Write response ready per port |
| dn_araddr | output | N_PORTS*ADDR_W | Read address per port |
| dn_arprot | output | N_PORTS*3 | Read protection per port |
| dn_arvalid | output | N_PORTS | Gated read address valid per port |
| dn_arready | input | N_PORTS | Read address ready per port |
| dn_rdata | input | N_PORTS*DATA_W | Read data per port |
| dn_rresp | input | N_PORTS*2 | Read response code per port |
| dn_rvalid | input | N_PORTS | Read response valid per port |
| dn_rready | output | N_PORTS | Read response ready per port |

## Verification
The bench uses four ports: three with windows and one without. It sweeps write addresses on each window edge, one past each edge, and with upper bits set, all with the read address taken from a different point of the same list. This tells a shared gate apart from separate read and write gates, and a full-width compare apart from a low-bit compare. For every address pair, all sixteen downstream ready patterns are applied. This separates a plain OR from a gated OR and shows whether an always-ready windowed port leaks acknowledges. Single-port and idle response patterns show that each response field comes from the answering port and is zero when no port answers.

// File: rtl/lbf_pkg.sv
package lbf_pkg;

  typedef logic [1:0] resp_t;

  // true when lo lies in [base, base+size); all operands zero-extended
  function automatic logic win_hit(logic [63:0] lo, logic [63:0] base, logic [63:0] size);
    return (lo >= base) && ((lo - base) < size);
  endfunction

endpackage

// File: rtl/lbf_port_gate.sv
module lbf_port_gate #(
  parameter int unsigned             CMP_W    = 28,
  parameter bit                      WIN_EN   = 1'b0,
  parameter logic [CMP_W-1:0]        WIN_BASE = '0,
  parameter logic [CMP_W-1:0]        WIN_SIZE = '0
) (
  input  logic [CMP_W-1:0] wr_addr_lo,
  input  logic [CMP_W-1:0] rd_addr_lo,
  input  logic             awvalid_i,
  input  logic             wvalid_i,
  input  logic             arvalid_i,
  input  logic             awready_i,
  input  logic             wready_i,
  input  logic             arready_i,
  output logic             awvalid_o,
  output logic             wvalid_o,
  output logic             arvalid_o,
  output logic             awready_o,
  output logic             wready_o,
  output logic             arready_o
);
  import lbf_pkg::*;

  logic wr_hit, rd_hit, wr_pass, rd_pass;

  assign wr_hit = win_hit(64'(wr_addr_lo), 64'(WIN_BASE), 64'(WIN_SIZE));
  assign rd_hit = win_hit(64'(rd_addr_lo), 64'(WIN_BASE), 64'(WIN_SIZE));

  generate
    if (WIN_EN) begin : g_win
      assign wr_pass = wr_hit;
      assign rd_pass = rd_hit;
    end else begin : g_open
      assign wr_pass = 1'b1 | wr_hit;
      assign rd_pass = 1'b1 | rd_hit;
    end
  endgenerate

  assign awvalid_o = awvalid_i & wr_pass;
  assign wvalid_o  = wvalid_i  & wr_pass;
  assign awready_o = awready_i & wr_pass;
  assign wready_o  = wready_i  & wr_pass;
  assign arvalid_o = arvalid_i & rd_pass;
  assign arready_o = arready_i & rd_pass;

  always_comb begin
    // R3
    if (awvalid_o || wvalid_o) begin
      wr_no_invent_chk: assert ((awvalid_o -> awvalid_i) && (wvalid_o -> wvalid_i));
    end
    // R4
    if (arvalid_o) begin
      rd_no_invent_chk: assert (arvalid_i);
    end
  end

endmodule

// File: rtl/lbf_resp_merge.sv
module lbf_resp_merge #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned W       = 2
) (
  input  logic [N_PORTS-1:0]   valid_i,
  input  logic [N_PORTS*W-1:0] data_i,
  output logic                 valid_o,
  output logic [W-1:0]         data_o
);

  always_comb begin
    valid_o = 1'b0;
    data_o  = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      valid_o = valid_o | valid_i[k];
      if (valid_i[k]) data_o = data_o | data_i[k*W +: W];
    end
  end

  always_comb begin
    // R6 R7: at most one responder at a time
    single_responder_chk: assert ($onehot0(valid_i));
  end

endmodule

// File: rtl/lbf_fanout.sv
module lbf_fanout #(
  parameter int unsigned                    N_PORTS  = 4,
  parameter int unsigned                    ADDR_W   = 32,
  parameter int unsigned                    DATA_W   = 32,
  parameter int unsigned                    CMP_W    = 28,
  parameter logic [N_PORTS-1:0]             WIN_EN   = '0,
  parameter logic [N_PORTS*CMP_W-1:0]       WIN_BASE = '0,
  parameter logic [N_PORTS*CMP_W-1:0]       WIN_SIZE = '0,
  localparam int unsigned                   STRB_W   = DATA_W / 8
) (
  input  logic [ADDR_W-1:0]          up_awaddr,
  input  logic [2:0]                 up_awprot,
  input  logic                       up_awvalid,
  output logic                       up_awready,
  input  logic [DATA_W-1:0]          up_wdata,
  input  logic [STRB_W-1:0]          up_wstrb,
  input  logic                       up_wvalid,
  output logic                       up_wready,
  output logic [1:0]                 up_bresp,
  output logic                       up_bvalid,
  input  logic                       up_bready,
  input  logic [ADDR_W-1:0]          up_araddr,
  input  logic [2:0]                 up_arprot,
  input  logic                       up_arvalid,
  output logic                       up_arready,
  output logic [DATA_W-1:0]          up_rdata,
  output logic [1:0]                 up_rresp,
  output logic                       up_rvalid,
  input  logic                       up_rready,
  output logic [N_PORTS*ADDR_W-1:0]  dn_awaddr,
  output logic [N_PORTS*3-1:0]       dn_awprot,
  output logic [N_PORTS-1:0]         dn_awvalid,
  input  logic [N_PORTS-1:0]         dn_awready,
  output logic [N_PORTS*DATA_W-1:0]  dn_wdata,
  output logic [N_PORTS*STRB_W-1:0]  dn_wstrb,
  output logic [N_PORTS-1:0]         dn_wvalid,
  input  logic [N_PORTS-1:0]         dn_wready,
  input  logic [N_PORTS*2-1:0]       dn_bresp,
  input  logic [N_PORTS-1:0]         dn_bvalid,
  output logic [N_PORTS-1:0]         dn_bready,
  output logic [N_PORTS*ADDR_W-1:0]  dn_araddr,
  output logic [N_PORTS*3-1:0]       dn_arprot,
  output logic [N_PORTS-1:0]         dn_arvalid,
  input  logic [N_PORTS-1:0]         dn_arready,
  input  logic [N_PORTS*DATA_W-1:0]  dn_rdata,
  input  logic [N_PORTS*2-1:0]       dn_rresp,
  input  logic [N_PORTS-1:0]         dn_rvalid,
  output logic [N_PORTS-1:0]         dn_rready
);

  localparam int unsigned RPACK_W = DATA_W + 2;

  logic [N_PORTS-1:0]         aw_rdy_g, w_rdy_g, ar_rdy_g;
  logic [N_PORTS*RPACK_W-1:0] r_pack;
  logic [RPACK_W-1:0]         r_sel;

  generate
    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
      assign dn_awaddr[g*ADDR_W +: ADDR_W] = up_awaddr;
      assign dn_awprot[g*3 +: 3]           = up_awprot;
      assign dn_wdata[g*DATA_W +: DATA_W]  = up_wdata;
      assign dn_wstrb[g*STRB_W +: STRB_W]  = up_wstrb;
      assign dn_araddr[g*ADDR_W +: ADDR_W] = up_araddr;
      assign dn_arprot[g*3 +: 3]           = up_arprot;
      assign dn_bready[g]                  = up_bready;
      assign dn_rready[g]                  = up_rready;
      assign r_pack[g*RPACK_W +: RPACK_W]  = {dn_rdata[g*DATA_W +: DATA_W], dn_rresp[g*2 +: 2]};

      lbf_port_gate #(
        .CMP_W   (CMP_W),
        .WIN_EN  (WIN_EN[g]),
        .WIN_BASE(WIN_BASE[g*CMP_W +: CMP_W]),
        .WIN_SIZE(WIN_SIZE[g*CMP_W +: CMP_W])
      ) u_gate (
        .wr_addr_lo(up_awaddr[CMP_W-1:0]),
        .rd_addr_lo(up_araddr[CMP_W-1:0]),
        .awvalid_i (up_awvalid),
        .wvalid_i  (up_wvalid),
        .arvalid_i (up_arvalid),
        .awready_i (dn_awready[g]),
        .wready_i  (dn_wready[g]),
        .arready_i (dn_arready[g]),
        .awvalid_o (dn_awvalid[g]),
        .wvalid_o  (dn_wvalid[g]),
        .arvalid_o (dn_arvalid[g]),
        .awready_o (aw_rdy_g[g]),
        .wready_o  (w_rdy_g[g]),
        .arready_o (ar_rdy_g[g])
      );
    end
  endgenerate

  assign up_awready = |aw_rdy_g;
  assign up_wready  = |w_rdy_g;
  assign up_arready = |ar_rdy_g;

  lbf_resp_merge #(.N_PORTS(N_PORTS), .W(2)) u_bmerge (
    .valid_i(dn_bvalid),
    .data_i (dn_bresp),
    .valid_o(up_bvalid),
    .data_o (up_bresp)
  );

  lbf_resp_merge #(.N_PORTS(N_PORTS), .W(RPACK_W)) u_rmerge (
    .valid_i(dn_rvalid),
    .data_i (r_pack),
    .valid_o(up_rvalid),
    .data_o (r_sel)
  );

  assign up_rdata = r_sel[RPACK_W-1:2];
  assign up_rresp = r_sel[1:0];

  always_comb begin
    // R2
    if (up_awready || up_wready) begin
      wr_ready_source_chk: assert ((up_awready -> |dn_awready) && (up_wready -> |dn_wready));
    end
    // R4
    if (up_arready) begin
      rd_ready_source_chk: assert (|dn_arready);
    end
  end

endmodule

// File: tb/test_lbf_fanout.sv
module test_lbf_fanout;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 28;
  localparam logic [N-1:0]    EN   = 4'b1011;
  localparam logic [N*CW-1:0] BASE = {28'h0004000, 28'h0, 28'h0000800, 28'h0000000};
  localparam logic [N*CW-1:0] SIZE = {28'h0000100, 28'h0, 28'h0000800, 28'h0000800};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [AW-1:0] up_awaddr, up_araddr;
  logic [2:0] up_awprot, up_arprot;
  logic up_awvalid, up_wvalid, up_arvalid, up_bready, up_rready;
  logic up_awready, up_wready, up_arready, up_bvalid, up_rvalid;
  logic [DW-1:0] up_wdata, up_rdata;
  logic [3:0] up_wstrb;
  logic [1:0] up_bresp, up_rresp;
  logic [N*AW-1:0] dn_awaddr, dn_araddr;
  logic [N*3-1:0] dn_awprot, dn_arprot;
  logic [N-1:0] dn_awvalid, dn_awready, dn_wvalid, dn_wready, dn_bvalid, dn_bready;
  logic [N-1:0] dn_arvalid, dn_arready, dn_rvalid, dn_rready;
  logic [N*DW-1:0] dn_wdata, dn_rdata;
  logic [N*4-1:0] dn_wstrb;
  logic [N*2-1:0] dn_bresp, dn_rresp;

  lbf_fanout #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW), .CMP_W(CW),
               .WIN_EN(EN), .WIN_BASE(BASE), .WIN_SIZE(SIZE)) i_lbf_fanout (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic gate_ok(int p, logic [AW-1:0] a);
    logic [63:0] lo, b, s;
    lo = 64'(a[CW-1:0]);
    b  = 64'(BASE[p*CW +: CW]);
    s  = 64'(SIZE[p*CW +: CW]);
    return !EN[p] || (lo >= b && lo - b < s);
  endfunction

  function automatic logic [N-1:0] gate_vec(logic [AW-1:0] a);
    logic [N-1:0] v;
    for (int p = 0; p < N; p++) v[p] = gate_ok(p, a);
    return v;
  endfunction

  logic [AW-1:0] addrs [0:8];
  initial begin
    addrs[0] = 32'h0000_0000; addrs[1] = 32'h0000_07FF; addrs[2] = 32'h0000_0800;
    addrs[3] = 32'h0000_0FFF; addrs[4] = 32'h0000_1000; addrs[5] = 32'hF000_0400;
    addrs[6] = 32'h0000_40FF; addrs[7] = 32'h0000_4100; addrs[8] = 32'h3000_4000;
  end

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  initial begin
    up_awaddr = '0; up_araddr = '0; up_awprot = '0; up_arprot = '0;
    up_awvalid = 0; up_wvalid = 0; up_arvalid = 0; up_bready = 0; up_rready = 0;
    up_wdata = '0; up_wstrb = '0;
    dn_awready = '0; dn_wready = '0; dn_arready = '0; dn_bvalid = '0; dn_rvalid = '0;
    dn_bresp = '0; dn_rresp = '0; dn_rdata = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    step();
    // idle state after reset
    chk("R2 idle readies", {up_awready, up_wready, up_arready}, 3'b000);
    chk("R6 idle bvalid/bresp", {up_bvalid, up_bresp}, 3'b000);
    chk("R7 idle rvalid/rdata", {up_rvalid, up_rresp, up_rdata}, '0);
    chk("R3 idle valids", {dn_awvalid, dn_wvalid, dn_arvalid}, '0);

    // request sweep: write and read addresses differ, all ready patterns
    for (int ai = 0; ai < 9; ai++) begin
      for (int rp = 0; rp < 16; rp++) begin
        logic [AW-1:0] wa, ra;
        logic [N-1:0] wg, rg, awr, wr, arr;
        wa = addrs[ai];
        ra = addrs[(ai + 3) % 9];
        awr = 4'(rp);
        wr  = 4'(rp ^ 5);
        arr = 4'(~rp);
        up_awaddr = wa; up_araddr = ra;
        up_awprot = 3'(ai); up_arprot = 3'(rp);
        up_wdata = {wa[15:0], 12'h0, 4'(rp)}; up_wstrb = 4'(rp);
        up_awvalid = rp[0]; up_wvalid = rp[1]; up_arvalid = 1'b1;
        up_bready = rp[2]; up_rready = rp[3];
        dn_awready = awr; dn_wready = wr; dn_arready = arr;
        step();
        wg = gate_vec(wa);
        rg = gate_vec(ra);
        chk("R1 awaddr broadcast", dn_awaddr, {N{wa}});
        chk("R1 araddr broadcast", dn_araddr, {N{ra}});
        chk("R1 prot broadcast", {dn_awprot, dn_arprot}, {{N{3'(ai)}}, {N{3'(rp)}}});
        chk("R1 wdata/wstrb broadcast", {dn_wdata, dn_wstrb}, {{N{up_wdata}}, {N{4'(rp)}}});
        chk("R3 awvalid gating", dn_awvalid, {N{rp[0]}} & wg);
        chk("R3 wvalid gating", dn_wvalid, {N{rp[1]}} & wg);
        chk("R4 arvalid gating", dn_arvalid, rg);
        chk("R2 R3 awready or", up_awready, |(awr & wg));
        chk("R2 R3 wready or", up_wready, |(wr & wg));
        chk("R2 R4 arready or", up_arready, |(arr & rg));
        chk("R8 bready/rready", {dn_bready, dn_rready}, {{N{rp[2]}}, {N{rp[3]}}});
      end
    end

    // R5: upper bits ignored
    up_awaddr = 32'hF000_0400; up_araddr = 32'h0000_0400;
    dn_awready = 4'b0001; dn_wready = 4'b0001; dn_arready = 4'b0001;
    step();
    chk("R5 upper bits ignored write", {up_awready, up_wready}, 2'b11);
    chk("R5 upper bits same gate as plain", up_arready, 1'b1);

    // R9: always-ready port 0, others silent
    for (int ai = 0; ai < 9; ai++) begin
      logic e;
      up_awaddr = addrs[ai]; up_araddr = addrs[ai];
      up_awvalid = 1; up_wvalid = 1; up_arvalid = 1;
      dn_awready = 4'b0001; dn_wready = 4'b0001; dn_arready = 4'b0001;
      step();
      e = (addrs[ai][CW-1:0] < 28'h800);
      chk("R9 early-ready port contained", {up_awready, up_wready, up_arready}, {3{e}});
    end

    // R6 R7: each single responder and none
    for (int p = -1; p < N; p++) begin
      logic [N-1:0] v;
      v = (p < 0) ? '0 : (4'b1 << p);
      for (int k = 0; k < N; k++) begin
        dn_bresp[k*2 +: 2] = 2'(k + 1);
        dn_rresp[k*2 +: 2] = 2'(3 - k);
        dn_rdata[k*DW +: DW] = 32'hC0DE_0000 + 32'(k * 17);
      end
      dn_bvalid = v; dn_rvalid = v;
      step();
      chk("R6 bvalid", up_bvalid, |v);
      chk("R6 bresp source", up_bresp, (p < 0) ? 2'b00 : 2'(p + 1));
      chk("R7 rvalid", up_rvalid, |v);
      chk("R7 rresp source", up_rresp, (p < 0) ? 2'b00 : 2'(3 - p));
      chk("R7 rdata source", up_rdata, (p < 0) ? 32'h0 : 32'hC0DE_0000 + 32'(p * 17));
    end
    dn_bvalid = '0; dn_rvalid = '0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule